// File: doc/BRIEF.md
# Parallel Mask ROM Read Controller

This block sits between a synchronous host and an asynchronous parallel mask ROM that can be read either eight bits or sixteen bits at a time. The host hands over a byte address together with a width flag. The controller then drives the ROM's active-low select and output-gate strobes, its width pin and its address lines. It waits a fixed number of clock cycles so that the ROM's access times are covered, samples the data lines, and returns the result with a single-cycle valid strobe.

In 8-bit mode the ROM's top data line is an input to the ROM. It carries the lowest byte-address bit, so the controller drives that line itself and then releases it. In 16-bit mode the controller reads the same line as data bit 15.

Two access styles are available:
- **Gated access.** The address is set up first, the select is pulsed low for each read, and the ROM goes back to standby between reads.
- **Paced access.** While `burst_keep` is high, the select stays low and further reads of the same width are clocked out by changing only the address.

Each style has its own wait count, and both counts are parameters expressed in cycles.

Top module: `romrd_ctrl`

## Requirements
- R1: After reset `rom_cs_n` and `rom_oe_n` are 1, `rd_valid` is 0, `q15_oe` is 0 and `req_ready` is 1.
- R2: A request with `req_word`=1 sets `rom_wide` to 1, puts byte-address bits [ADDR_W:1] on `rom_addr` (byte-address bit 0 is ignored), and returns all 16 `rom_q` lines as `rd_data`.
- R3: A request with `req_word`=0 sets `rom_wide` to 0, drives byte-address bits [ADDR_W:1] on `rom_addr` and bit 0 on `q15_out` with `q15_oe`=1, and returns `{8'h00, rom_q[7:0]}`. Lines `rom_q[15:8]` are ignored.
- R4: `rom_oe_n` is low only while `rom_cs_n` is low.
- R5: A gated access keeps the address on the pins for one cycle with `rom_cs_n` high before the select and output gate fall. It samples the data max(TACE_CYC, TOE_CYC) cycles later, so `rd_valid` appears 1+max(TACE_CYC, TOE_CYC) cycles after acceptance.
- R6: With `burst_keep`=0 the select and output gate rise in the same edge that captures the data. `rom_cs_n` then stays high for at least TDF_CYC+2 cycles before it falls again.
- R7: With `burst_keep`=1, a following request of the same width is accepted while `rom_cs_n` stays low. Its data is sampled TAA_CYC cycles after the address change, and the select does not rise anywhere in the burst.
- R8: A request of the other width during a burst is not accepted at once. The controller first raises the select for the recovery period and then performs a gated access. `q15_oe` only rises on an edge where `rom_cs_n` was already high.
- R9: `rd_valid` is a one-cycle pulse, issued exactly once for every accepted request. `req_ready` is high only when idle, or when holding a burst with `burst_keep`=1 and a request of matching width.
- R10: `rom_addr` and `q15_out` stay constant for every cycle of an access, up to and including the capture edge.
- R11: While holding a burst with no request pending, the select and output gate stay low. Dropping `burst_keep` starts the recovery on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | ADDR_W+1 | Byte address |
| req_word | input | 1 | 1 = 16-bit read, 0 = 8-bit read |
| burst_keep | input | 1 | Keep the select low for paced reads |
| rd_data | output | 16 | Returned read data |
| rd_valid | output | 1 | One-cycle data strobe |
| rom_cs_n | output | 1 | ROM select, active low |
| rom_oe_n | output | 1 | ROM output gate, active low |
| rom_wide | output | 1 | ROM width pin: 0 = 8-bit, 1 = 16-bit |
| rom_addr | output | ADDR_W | ROM word address lines |
| rom_q | input | 16 | ROM data lines |
| q15_out | output | 1 | Value driven onto the top data line in 8-bit mode |
| q15_oe | output | 1 | Drive enable for the top data line |

## Verification
The ROM model in the bench outputs the complement of the correct data whenever the select, output-gate or address-stability windows are shorter than their parameters. An access that samples one cycle too early therefore returns a visibly wrong value.

The bench runs several sweeps on an 8-bit word address space:
- every word address in gated style, with byte-address bit 0 toggled to show that it is ignored;
- every byte address in gated style;
- every word address in paced style, going up;
- every byte address in paced style, going down.

These sweeps separate the gated wait from the paced wait, and 8-bit lane steering from 16-bit lane steering. Width switches inside a burst, and an idle hold inside a burst, show that recovery and the top-line turnaround are respected and that the select is kept low only when it should be.

// File: rtl/romrd_pkg.sv
package romrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_RECOVER
  } rr_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/romrd_timer.sv
module romrd_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/romrd_datapath.sv
module romrd_datapath #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W:0]   ld_addr,
  input  logic              ld_word,
  input  logic              drop_q15,
  input  logic              capture,
  input  logic [15:0]       rom_q,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_wide,
  output logic              q15_out,
  output logic              q15_oe,
  output logic [15:0]       rd_data
);

  // Address, width pin and top-line drive are all registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_wide <= 1'b0;
      q15_out  <= 1'b0;
      q15_oe   <= 1'b0;
    end else if (load) begin
      rom_addr <= ld_addr[ADDR_W:1];
      rom_wide <= ld_word;
      q15_out  <= ld_addr[0];
      q15_oe   <= ~ld_word;
    end else if (drop_q15) begin
      q15_oe   <= 1'b0;
    end
  end

  // Lane steering: 8-bit reads are zero-extended and ignore the upper lines.
  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (capture) rd_data <= rom_wide ? rom_q : {8'h00, rom_q[7:0]};
  end

endmodule

// File: rtl/romrd_ctrl.sv
module romrd_ctrl
  import romrd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int TACE_CYC = 15,
  parameter int TAA_CYC  = 15,
  parameter int TOE_CYC  = 7,
  parameter int TDF_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_word,
  input  logic              burst_keep,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              rom_cs_n,
  output logic              rom_oe_n,
  output logic              rom_wide,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [15:0]       rom_q,
  output logic              q15_out,
  output logic              q15_oe
);

  localparam int GATE_CYC = imax(TACE_CYC, TOE_CYC);
  localparam int MAX_CYC  = imax(imax(GATE_CYC, TAA_CYC), TDF_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  rr_state_e        state;
  logic             tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, same_mode, leave_hold, capture, drop_q15;

  assign same_mode  = (req_word == rom_wide);
  assign req_ready  = (state == ST_IDLE) ||
                      (state == ST_HOLD && burst_keep && same_mode);
  assign accept     = req_valid && req_ready;
  assign capture    = (state == ST_ACCESS) && tmr_zero;
  assign leave_hold = !burst_keep || (req_valid && !same_mode);
  assign drop_q15   = (state == ST_RECOVER) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(GATE_CYC - 1);
      end
      ST_ACCESS: if (tmr_zero && !burst_keep) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TDF_CYC - 1);
      end
      ST_HOLD: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TAA_CYC - 1);
      end else if (leave_hold) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TDF_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rom_cs_n <= 1'b1;
      rom_oe_n <= 1'b1;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE:  if (accept) state <= ST_SETUP;
        ST_SETUP: begin
          state    <= ST_ACCESS;
          rom_cs_n <= 1'b0;
          rom_oe_n <= 1'b0;
        end
        ST_ACCESS: if (tmr_zero) begin
          rd_valid <= 1'b1;
          if (burst_keep) begin
            state <= ST_HOLD;
          end else begin
            state    <= ST_RECOVER;
            rom_cs_n <= 1'b1;
            rom_oe_n <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (accept) begin
            state <= ST_ACCESS;
          end else if (leave_hold) begin
            state    <= ST_RECOVER;
            rom_cs_n <= 1'b1;
            rom_oe_n <= 1'b1;
          end
        end
        ST_RECOVER: if (tmr_zero) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  romrd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  romrd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .ld_addr  (req_addr),
    .ld_word  (req_word),
    .drop_q15 (drop_q15),
    .capture  (capture),
    .rom_q    (rom_q),
    .rom_addr (rom_addr),
    .rom_wide (rom_wide),
    .q15_out  (q15_out),
    .q15_oe   (q15_oe),
    .rd_data  (rd_data)
  );

  // R4: output gate never active without select
  p_oe_with_cs_r4: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_cs_n);

  // R9: valid strobe lasts one cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R3: top line driven only in 8-bit mode; byte result zero-extended
  p_q15_byte_only_r3: assert property (@(posedge clk) disable iff (rst)
    q15_oe |-> !rom_wide);
  p_byte_zero_ext_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rom_wide) |-> (rd_data[15:8] == 8'h00));

  // R2: 16-bit result equals the lines sampled at the capture edge
  p_word_data_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rom_wide) |-> (rd_data == $past(rom_q)));

  // R8: the top line turns around only while the ROM is deselected
  p_q15_turn_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(q15_oe) |-> $past(rom_cs_n));

  // R10: address lines frozen during an access
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACCESS && $past(state == ST_ACCESS)) |->
      ($stable(rom_addr) && $stable(q15_out)));

  // R1: idle means standby
  p_idle_standby_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (rom_cs_n && rom_oe_n));

endmodule

// File: tb/romrd_ctrl_test.sv
module romrd_ctrl_test;

  localparam int AW   = 8;
  localparam int TACE = 4;
  localparam int TAA  = 3;
  localparam int TOE  = 2;
  localparam int TDF  = 2;
  localparam int GATE = (TACE > TOE) ? TACE : TOE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW:0]   req_addr = '0;
  logic          req_word = 1'b0;
  logic          burst_keep = 1'b0;
  logic [15:0]   rd_data;
  logic          rd_valid;
  logic          rom_cs_n, rom_oe_n, rom_wide, q15_out, q15_oe;
  logic [AW-1:0] rom_addr;
  logic [15:0]   rom_q;

  int checks = 0;
  int fails = 0;
  int reads = 0;
  int pulses = 0;
  int rises = 0;
  int lat = 0;

  always #4 clk = ~clk;

  romrd_ctrl #(.ADDR_W(AW), .TACE_CYC(TACE), .TAA_CYC(TAA),
               .TOE_CYC(TOE), .TDF_CYC(TDF)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .burst_keep(burst_keep),
    .rd_data(rd_data), .rd_valid(rd_valid), .rom_cs_n(rom_cs_n),
    .rom_oe_n(rom_oe_n), .rom_wide(rom_wide), .rom_addr(rom_addr),
    .rom_q(rom_q), .q15_out(q15_out), .q15_oe(q15_oe));

  function automatic logic [15:0] wfun(input int wa);
    return 16'((wa * 40503 + 4660) ^ (wa << 5));
  endfunction

  function automatic logic [7:0] bfun(input int ba);
    return 8'((ba * 37 + 91) ^ (ba >> 3));
  endfunction

  // ROM model: correct data only once every timing window is met
  logic [7:0] ce_cnt, oe_cnt, ad_cnt;
  logic [AW+1:0] key, last_key;
  assign key = {rom_wide, rom_addr, rom_wide ? 1'b0 : q15_out};

  always_ff @(posedge clk) begin
    ce_cnt   <= rom_cs_n ? 8'd0 : ((ce_cnt == 8'hFF) ? ce_cnt : ce_cnt + 8'd1);
    oe_cnt   <= rom_oe_n ? 8'd0 : ((oe_cnt == 8'hFF) ? oe_cnt : oe_cnt + 8'd1);
    ad_cnt   <= (key != last_key) ? 8'd1 : ((ad_cnt == 8'hFF) ? ad_cnt : ad_cnt + 8'd1);
    last_key <= key;
  end

  always_comb begin
    logic [15:0] good;
    good = rom_wide ? wfun(int'(rom_addr))
                    : {8'hA5, bfun(int'({rom_addr, q15_out}))};
    if (rom_cs_n || rom_oe_n) rom_q = 16'h0F0F;
    else if (int'(ce_cnt) >= TACE - 1 && int'(oe_cnt) >= TOE - 1 &&
             int'(ad_cnt) >= TAA - 1) rom_q = good;
    else rom_q = ~good;
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitors: select gap, output gate vs select, pulse count, contention
  int hi_run = 0;
  logic prev_cs = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) pulses++;
      if (!prev_cs && rom_cs_n) rises++;
      if (!rom_cs_n && prev_cs && hi_run < TDF + 2) begin
        checks++; fails++;
        $display("FAIL R6 cs_n high run actual=%0d expected>=%0d", hi_run, TDF + 2);
      end
      if (!rom_oe_n && rom_cs_n) begin
        checks++; fails++;
        $display("FAIL R4 oe_n low with cs_n high actual=1 expected=0");
      end
      if (q15_oe && rom_wide) begin
        checks++; fails++;
        $display("FAIL R8 top line contention actual=1 expected=0");
      end
      hi_run = rom_cs_n ? hi_run + 1 : 0;
      prev_cs = rom_cs_n;
    end
  end

  task automatic do_read(input int ba, input logic wide, input logic keep,
                         input int exp_lat, input string req);
    logic [15:0] exp;
    @(negedge clk);
    req_addr   = (AW + 1)'(ba);
    req_word   = wide;
    burst_keep = keep;
    req_valid  = 1'b1;
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    reads++;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!rd_valid && lat < 100);
    exp = wide ? wfun(ba >> 1) : {8'h00, bfun(ba)};
    check({req, " data"}, 32'(rd_data), 32'(exp));
    if (exp_lat > 0) check({req, " latency"}, lat, exp_lat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cs_n", rom_cs_n, 1);
    check("R1 oe_n", rom_oe_n, 1);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 q15_oe", q15_oe, 0);
    check("R1 ready", req_ready, 1);

    // R2/R5/R6: gated 16-bit sweep, byte-address bit 0 toggled
    for (int w = 0; w < (1 << AW); w++) begin
      do_read((w << 1) | (w & 1), 1'b1, 1'b0, 1 + GATE, "R2 R5 gated word");
      check("R6 standby after capture", rom_cs_n, 1);
    end

    // R3/R5: gated 8-bit sweep over every byte address
    for (int b = 0; b < (2 << AW); b++) begin
      do_read(b, 1'b0, 1'b0, 1 + GATE, "R3 R5 gated byte");
      if (b == 5) begin
        check("R3 q15_oe during byte", q15_oe, 1);
        check("R3 q15_out", q15_out, 1);
      end
    end
    repeat (6) @(negedge clk);

    // R7: paced 16-bit sweep going up
    r0 = rises;
    do_read(0, 1'b1, 1'b1, 1 + GATE, "R7 burst first");
    for (int w = 1; w < (1 << AW); w++)
      do_read(w << 1, 1'b1, 1'b1, TAA, "R7 paced word");
    check("R7 no select rise in word burst", rises - r0, 0);

    // R11: hold without request keeps select low, then paced read
    repeat (10) @(negedge clk);
    check("R11 hold cs_n", rom_cs_n, 0);
    check("R11 hold oe_n", rom_oe_n, 0);
    do_read(34, 1'b1, 1'b1, TAA, "R11 paced after hold");

    // R8: width switch inside a burst goes through recovery
    r0 = rises;
    do_read(77, 1'b0, 1'b1, 0, "R8 switch to byte");
    check("R8 select rose on switch", rises - r0, 1);

    // R7: paced 8-bit sweep going down
    r0 = rises;
    for (int b = (2 << AW) - 1; b >= 0; b--)
      do_read(b, 1'b0, 1'b1, TAA, "R7 paced byte");
    check("R7 no select rise in byte burst", rises - r0, 0);

    r0 = rises;
    do_read(300, 1'b1, 1'b1, 0, "R8 switch to word");
    check("R8 select rose on switch back", rises - r0, 1);

    // R11: dropping burst_keep starts recovery on the next edge
    @(negedge clk);
    burst_keep = 1'b0;
    @(negedge clk);
    check("R11 release cs_n", rom_cs_n, 1);
    check("R11 release oe_n", rom_oe_n, 1);
    repeat (6) @(negedge clk);
    check("R9 pulse count", pulses, reads);
    check("R9 ready when idle", req_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule